// File: doc/BRIEF.md
# Four-Phase Handshake Word Crossing

This block moves one multi-bit word at a time from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. The source accepts a word through a valid/ready load, holds it in a register, and one source cycle later raises a request level. The destination passes that request through a flop chain, captures the held word on the first synchronized rising edge, and shows it for one destination cycle on a data-valid strobe. The synchronized request is returned as an acknowledge level, which the source passes through its own flop chain before it withdraws the request.

The protocol has four phases: request up, acknowledge up, request down, acknowledge down. Only after the last phase does the source take another word, so exactly one control level changes at any moment and the word register never changes while the destination might sample it. Each domain has its own active-low asynchronous reset. The chain depth is a parameter that selects two or three flops.

Top module: `hs_cdc_xfer`

## Requirements
- R1: After reset `src_ready` is 1 and `dst_valid` is 0.
- R2: The request level rises in the source cycle that follows the cycle in which the word register is loaded, so the word is stable before the request can be seen.
- R3: The source word register keeps its value from the load until the transfer returns to idle; the value on `src_data` after a load has no effect on the delivered word.
- R4: The request stays high until the synchronized acknowledge is high, then stays low until the synchronized acknowledge is low again.
- R5: A word is loaded only in a source cycle with `src_valid` and `src_ready` both 1; `src_ready` is 0 in the cycle after a load, and `src_valid` while `src_ready` is 0 loads nothing.
- R6: `dst_valid` is 1 for exactly one destination cycle per transfer, and `dst_data` changes only in that cycle.
- R7: Every accepted word appears on `dst_data` exactly once, in the order of acceptance, whether the destination clock is slower or faster than the source clock.
- R8: `SYNC_STAGES` set to 2 gives two-flop chains and set to 3 gives three-flop chains; both depths deliver the same stream correctly.
- R9: Resetting only the destination domain while the source is idle clears `dst_valid`, leaves `src_ready` at 1, and later transfers still succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Block can accept a word this cycle |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle strobe marking a delivered word |
| dst_data | output | DATA_W | Delivered word, held until the next delivery |

## Verification
The assertions watch, on every clock, the local rules of each side: the request rising one cycle after a load, the word register frozen while a transfer is pending, the request held until the acknowledge answers, the ready line dropping after a load, and the destination strobe lasting a single cycle with the data bus moving only with it. What only the bench scenarios can show is the end-to-end property: that a random stream of words arrives exactly once and in order through both chain depths, with the destination clock both slower and faster than the source clock, that junk offered while the block is busy never leaks through, and that a destination-only reset leaves the source untouched.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_HOLD  = 2'd2,
    SRC_DRAIN = 2'd3
  } src_state_e;

  // Rising edge seen between two consecutive samples of a level.
  function automatic logic rise_seen(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Source may take a new word only with both handshake levels at rest.
  function automatic logic src_can_accept(input src_state_e st,
                                          input logic req_lvl,
                                          input logic ack_lvl);
    return (st == SRC_IDLE) & ~req_lvl & ~ack_lvl;
  endfunction

  // Chain depth actually built: 3 when asked for 3 or more, else 2.
  function automatic int chain_depth(input int asked);
    return (asked >= 3) ? 3 : 2;
  endfunction

endpackage

// File: rtl/cdc_sync_chain.sv
module cdc_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  import hs_cdc_pkg::*;

  localparam int DEPTH = chain_depth(STAGES);

  logic [DEPTH-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q[0] <= 1'b0;
    else        ff_q[0] <= d_async;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q[g] <= 1'b0;
      else        ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_sync = ff_q[DEPTH-1];

endmodule

// File: rtl/hs_src_ctl.sv
module hs_src_ctl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              ack_async,
  output logic              req_out,
  output logic [DATA_W-1:0] word_out
);
  import hs_cdc_pkg::*;

  src_state_e        st_q;
  logic              req_q;
  logic [DATA_W-1:0] word_q;
  logic              ack_s;
  logic              load_evt;
  logic              ack_seen;
  logic              ack_gone;

  cdc_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (src_clk),
    .rst_n   (src_rst_n),
    .d_async (ack_async),
    .q_sync  (ack_s)
  );

  assign src_ready = src_can_accept(st_q, req_q, ack_s);
  assign load_evt  = src_valid & src_ready;
  assign ack_seen  = (st_q == SRC_HOLD) & ack_s;
  assign ack_gone  = (st_q == SRC_DRAIN) & ~ack_s;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      st_q   <= SRC_IDLE;
      req_q  <= 1'b0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        SRC_IDLE: begin
          if (load_evt) begin
            word_q <= src_data;
            st_q   <= SRC_LOAD;
          end
        end
        SRC_LOAD: begin
          req_q <= 1'b1;
          st_q  <= SRC_HOLD;
        end
        SRC_HOLD: begin
          if (ack_seen) begin
            req_q <= 1'b0;
            st_q  <= SRC_DRAIN;
          end
        end
        SRC_DRAIN: begin
          if (ack_gone) st_q <= SRC_IDLE;
        end
        default: st_q <= SRC_IDLE;
      endcase
    end
  end

  assign req_out  = req_q;
  assign word_out = word_q;

  AST_REQ_AFTER_LOAD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    load_evt |=> (!req_q ##1 req_q)); // R2
  AST_WORD_FROZEN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (st_q != SRC_IDLE) |=> $stable(word_q)); // R3
  AST_REQ_HELD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (req_q && !ack_s) |=> req_q); // R4
  AST_REQ_DROP_NEEDS_ACK: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(req_q) |-> $past(ack_s)); // R4
  AST_READY_DROPS: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    load_evt |=> !src_ready); // R5

endmodule

// File: rtl/hs_dst_ctl.sv
module hs_dst_ctl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  input  logic              req_async,
  input  logic [DATA_W-1:0] word_in,
  output logic              ack_out,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  import hs_cdc_pkg::*;

  logic              req_s;
  logic              req_d;
  logic              take_evt;
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  cdc_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .d_async (req_async),
    .q_sync  (req_s)
  );

  assign take_evt = rise_seen(req_s, req_d);

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_d   <= 1'b0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      req_d   <= req_s;
      ack_q   <= req_s;
      valid_q <= take_evt;
      if (take_evt) data_q <= word_in;
    end
  end

  assign ack_out   = ack_q;
  assign dst_valid = valid_q;
  assign dst_data  = data_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid); // R6
  AST_DATA_MOVES_WITH_VALID: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$stable(dst_data) |-> dst_valid); // R6

endmodule

// File: rtl/hs_cdc_xfer.sv
module hs_cdc_xfer #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);

  logic              req_x;
  logic              ack_x;
  logic [DATA_W-1:0] word_x;

  hs_src_ctl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .ack_async (ack_x),
    .req_out   (req_x),
    .word_out  (word_x)
  );

  hs_dst_ctl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .req_async (req_x),
    .word_in   (word_x),
    .ack_out   (ack_x),
    .dst_valid (dst_valid),
    .dst_data  (dst_data)
  );

endmodule

// File: tb/sim_hs_cdc_xfer.sv
`timescale 1ns/1ps
module sim_hs_cdc_xfer;
  localparam int W = 8;
  localparam int NWORDS = 150;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic rdy0, rdy1, vld0, vld1;
  logic [W-1:0] dat0, dat1;
  real dst_half = 11.5;

  int n_chk = 0;
  int n_fail = 0;
  int tx = 0;
  int rx0 = 0;
  int rx1 = 0;
  bit pv0 = 0;
  bit pv1 = 0;
  bit done = 0;
  logic [W-1:0] exp_mem [0:2*NWORDS-1];

  hs_cdc_xfer #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_data(src_data), .src_ready(rdy0), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_valid(vld0), .dst_data(dat0));

  hs_cdc_xfer #(.DATA_W(W), .SYNC_STAGES(3)) u1 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_data(src_data), .src_ready(rdy1), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_valid(vld1), .dst_data(dat1));

  always #5 src_clk = ~src_clk;
  always begin
    #(dst_half);
    dst_clk = ~dst_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Destination monitors: order, uniqueness and single-cycle strobe.
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (vld0) begin
        chk(!pv0, "R6 u0 strobe longer than one cycle", 1, 0);
        if (rx0 >= tx) chk(1'b0, "R7 u0 extra word", rx0, tx - 1);
        else chk(dat0 == exp_mem[rx0], "R7 u0 word order", int'(dat0), int'(exp_mem[rx0]));
        rx0++;
      end
      if (vld1) begin
        chk(!pv1, "R6 R8 u1 strobe longer than one cycle", 1, 0);
        if (rx1 >= tx) chk(1'b0, "R8 u1 extra word", rx1, tx - 1);
        else chk(dat1 == exp_mem[rx1], "R8 u1 word order", int'(dat1), int'(exp_mem[rx1]));
        rx1++;
      end
    end
    pv0 = vld0;
    pv1 = vld1;
  end

  task automatic send_words(input int n);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      forever begin
        @(negedge src_clk);
        if (rdy0 && rdy1) break;
        if (!rdy0 && !rdy1) begin
          src_valid = 1'b1;            // offered while busy: must be ignored (R5)
          src_data  = W'($urandom);
        end else begin
          src_valid = 1'b0;
        end
      end
      src_valid = 1'b1;
      src_data  = w;
      exp_mem[tx] = w;
      tx++;
      @(negedge src_clk);
      chk(!rdy0 && !rdy1, "R5 ready after load", int'(rdy0) + int'(rdy1), 0);
      src_valid = 1'b0;
      src_data  = ~w;                  // changing the bus after load (R3)
      repeat ($urandom % 3) @(negedge src_clk);
    end
  endtask

  task automatic drain();
    while (rx0 < tx || rx1 < tx) @(negedge src_clk);
    repeat (20) @(negedge src_clk);
    chk(rx0 == tx, "R7 u0 count", rx0, tx);
    chk(rx1 == tx, "R8 u1 count", rx1, tx);
  endtask

  initial begin
    repeat (3) @(negedge src_clk);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    @(negedge src_clk);
    chk(rdy0 == 1'b1, "R1 u0 ready after reset", int'(rdy0), 1);
    chk(rdy1 == 1'b1, "R1 u1 ready after reset", int'(rdy1), 1);
    chk(vld0 == 1'b0 && vld1 == 1'b0, "R1 valid after reset", int'(vld0) + int'(vld1), 0);

    // Destination slower than source (R7, R2, R4, R3)
    dst_half = 11.5;
    send_words(NWORDS);
    drain();

    // Destination-only reset while idle (R9)
    @(negedge dst_clk);
    dst_rst_n = 1'b0;
    repeat (2) @(negedge src_clk);
    chk(rdy0 && rdy1, "R9 src ready during dst reset", int'(rdy0) + int'(rdy1), 2);
    chk(!vld0 && !vld1, "R9 valid during dst reset", int'(vld0) + int'(vld1), 0);
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    repeat (4) @(negedge src_clk);
    chk(rdy0 && rdy1, "R9 src ready after dst reset", int'(rdy0) + int'(rdy1), 2);

    // Destination faster than source (R7, R8)
    dst_half = 3.5;
    send_words(NWORDS);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge src_clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule